// File: doc/BRIEF.md
# Exception state register file

This block keeps the trap and interrupt state that a small multi-cycle processor needs when an exception is taken and later returned from. It holds three registers: the saved exception PC, a cause register, and a status register. The cause register holds pending flags for five hardware interrupt lines and a 4-bit exception code. The status register holds an 8-bit interrupt mask and a three-level stack of privilege/enable pairs.

The processor's controller decides when an exception happens. It pulses `take_i` together with a code and the already-advanced fetch PC. The block then saves the address of the faulting instruction, records the code and pushes the privilege stack. `eret_i` pops the stack. `irq_o` tells the controller that an enabled, unmasked interrupt is pending. `vec_o` gives the fixed handler address. Software reaches all three registers through a single-cycle read/write port.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, the saved PC, cause and status registers all read 0, and `irq_o` is 0.
- R2: When `take_i` is high at a clock edge, the saved PC becomes `fetch_pc_i - 4` and cause bits 5:2 become `code_i`; both are readable from the next cycle.
- R3: When `take_i` is high, status bits 5:0 shift left by two and the lowest pair becomes 00. In each pair the upper bit is the user/kernel bit (1 = user) and the lower bit is the interrupt enable bit.
- R4: When `eret_i` is high and `take_i` is low, status bits 5:2 move down to bits 3:0, and bits 5:4 keep their value.
- R5: `take_i` has priority over `eret_i` at the same edge. Both `take_i` and `eret_i` have priority over a software write of status bits 5:0 at the same edge. The mask bits of that write are still stored.
- R6: A 0-to-1 change on hardware line i (sampled at clock edges) sets cause bit 10+i. This happens whatever the mask and enable settings are.
- R7: A software write to the cause register (select 1) clears each pending bit whose write-data bit is 0. Writing 1 has no effect. A rising edge on the same line at the same edge wins, and the bit is set.
- R8: A pending bit is 0 in any cycle that follows an edge at which its line was sampled low.
- R9: `irq_o` is high exactly when status bit 0 is 1 and, for some line i, pending bit i and status bit 8+i are both 1.
- R10: `vec_o` always equals 0x80000080.
- R11: The select encoding is 0 = saved PC, 1 = cause, 2 = status, 3 = reads 0. Unimplemented bits read 0: cause bits 31:15, 9:6 and 1:0, and status bits 31:16 and 7:6. Software cannot write the exception code.
- R12: A software write with select 0 loads all 32 bits of the saved PC. A write with select 2 loads status bits 15:8 and 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception entry strobe |
| code_i | input | 4 | Exception code recorded on entry |
| fetch_pc_i | input | 32 | PC after fetch advance |
| hw_irq_i | input | 5 | Hardware interrupt request lines |
| eret_i | input | 1 | Return-from-exception strobe |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 2 | Register select |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read data for the selected register |
| irq_o | output | 1 | Enabled, unmasked interrupt pending |
| vec_o | output | 32 | Handler entry address |

## Verification
Two kinds of events can land in the same cycle. An exception entry or return can coincide with a software write to the status register. A new request edge can coincide with a software clear of the same pending bit. Directed steps force both collisions. The outcome is judged by reading every register back through the port and comparing it with a bench model that applies the priorities of R5 and R7. Long random runs, in which strobes, writes and line toggles overlap freely, check the same resolution many more times.

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter logic [31:0] HANDLER_VEC = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_i,
  input  logic [3:0]  code_i,
  input  logic [31:0] fetch_pc_i,
  input  logic [4:0]  hw_irq_i,
  input  logic        eret_i,
  input  logic        sw_we_i,
  input  logic [1:0]  sw_sel_i,
  input  logic [31:0] sw_wdata_i,
  output logic [31:0] sw_rdata_o,
  output logic        irq_o,
  output logic [31:0] vec_o
);
  logic [31:0] epc;
  logic [3:0]  code;
  logic [4:0]  pend, hw_q, sw_clr, rise;
  logic [7:0]  mask;
  logic [5:0]  ks;

  wire wr_epc   = sw_we_i && sw_sel_i == 2'd0;
  wire wr_cause = sw_we_i && sw_sel_i == 2'd1;
  wire wr_stat  = sw_we_i && sw_sel_i == 2'd2;

  assign sw_clr = wr_cause ? ~sw_wdata_i[14:10] : 5'b0;
  assign rise   = hw_irq_i & ~hw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc  <= '0;
      code <= '0;
      pend <= '0;
      hw_q <= '0;
      mask <= '0;
      ks   <= '0;
    end else begin
      hw_q <= hw_irq_i;
      pend <= hw_irq_i & ((pend & ~sw_clr) | rise);
      if (take_i) begin
        epc  <= fetch_pc_i - 32'd4;
        code <= code_i;
      end else if (wr_epc) begin
        epc <= sw_wdata_i;
      end
      if (wr_stat) mask <= sw_wdata_i[15:8];
      if (take_i)       ks <= {ks[3:0], 2'b00};
      else if (eret_i)  ks <= {ks[5:4], ks[5:2]};
      else if (wr_stat) ks <= sw_wdata_i[5:0];
    end
  end

  always_comb begin
    case (sw_sel_i)
      2'd0:    sw_rdata_o = epc;
      2'd1:    sw_rdata_o = {16'b0, 1'b0, pend, 4'b0, code, 2'b0};
      2'd2:    sw_rdata_o = {16'b0, mask, 2'b0, ks};
      default: sw_rdata_o = '0;
    endcase
  end

  assign irq_o = ks[0] && |(pend & mask[4:0]);
  assign vec_o = HANDLER_VEC;

  p_epc_saved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> epc == $past(fetch_pc_i) - 32'd4);

  p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (ks[1:0] == 2'b00) && (ks[5:2] == $past(ks[3:0])));

  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !take_i) |=> (ks[5:4] == $past(ks[5:4])) && (ks[3:0] == $past(ks[5:2])));

  p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 5'b0) |=> ((pend & $past(rise)) == $past(rise)));

  p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & ~$past(hw_irq_i)) == 5'b0);

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sw_sel_i != 2'd2 || sw_rdata_o[0]));
endmodule

// File: tb/sim_exc_state_regs.sv
module sim_exc_state_regs;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic take_i = 0, eret_i = 0, sw_we_i = 0;
  logic [3:0] code_i = 0;
  logic [31:0] fetch_pc_i = 0, sw_wdata_i = 0;
  logic [4:0] hw_irq_i = 0;
  logic [1:0] sw_sel_i = 0;
  logic [31:0] sw_rdata_o, vec_o;
  logic irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_epc;
  logic [3:0]  m_code;
  logic [4:0]  m_pend, m_hwq;
  logic [7:0]  m_mask;
  logic [5:0]  m_ks;

  exc_state_regs u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0:    return m_epc;
      2'd1:    return {16'b0, 1'b0, m_pend, 4'b0, m_code, 2'b0};
      2'd2:    return {16'b0, m_mask, 2'b0, m_ks};
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_ks[0] && |(m_pend & m_mask[4:0]);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    string nm[4] = '{"R12 epc", "R7 cause", "R3 status", "R11 sel3"};
    sw_we_i = 0;
    for (int s = 0; s < 4; s++) begin
      sw_sel_i = s[1:0];
      #1;
      check({tag, " ", nm[s]}, sw_rdata_o, exp_read(s[1:0]));
    end
    check({tag, " R9 irq"}, {31'b0, irq_o}, {31'b0, exp_irq()});
    check({tag, " R10 vec"}, vec_o, 32'h8000_0080);
  endtask

  task automatic step(input string tag, input logic tk, input logic [3:0] cd,
                      input logic [31:0] pc, input logic [4:0] hw, input logic er,
                      input logic we, input logic [1:0] sel, input logic [31:0] wd);
    logic [4:0] clr, rs;
    @(negedge clk);
    take_i = tk; code_i = cd; fetch_pc_i = pc; hw_irq_i = hw;
    eret_i = er; sw_we_i = we; sw_sel_i = sel; sw_wdata_i = wd;
    @(posedge clk);
    clr = (we && sel == 2'd1) ? ~wd[14:10] : 5'b0;
    rs  = hw & ~m_hwq;
    m_pend = hw & ((m_pend & ~clr) | rs);
    m_hwq  = hw;
    if (tk) begin m_epc = pc - 32'd4; m_code = cd; end
    else if (we && sel == 2'd0) m_epc = wd;
    if (we && sel == 2'd2) m_mask = wd[15:8];
    if (tk)      m_ks = {m_ks[3:0], 2'b00};
    else if (er) m_ks = {m_ks[5:4], m_ks[5:2]};
    else if (we && sel == 2'd2) m_ks = wd[5:0];
    #1;
    take_i = 0; eret_i = 0;
    compare_all(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_epc = 0; m_code = 0; m_pend = 0; m_hwq = 0; m_mask = 0; m_ks = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 compare_all("R1 reset");

    step("R12 status", 0, 0, 0, 5'b00000, 0, 1, 2'd2, 32'h0000_1F01);
    step("R12 epc",    0, 0, 0, 5'b00000, 0, 1, 2'd0, 32'h1234_5678);
    step("R6 rise",    0, 0, 0, 5'b00001, 0, 0, 2'd0, 0);
    step("R2 take",    1, 4'd12, 32'h0000_0400, 5'b00001, 0, 0, 2'd0, 0);
    step("R4 eret",    0, 0, 0, 5'b00001, 1, 0, 2'd0, 0);
    step("R5 take+eret", 1, 4'd8, 32'h0000_1000, 5'b00001, 1, 0, 2'd0, 0);
    step("R5 take+wr",   1, 4'd10, 32'h0000_2004, 5'b00001, 0, 1, 2'd2, 32'h0000_AB3F);
    step("R5 eret+wr",   0, 0, 0, 5'b00001, 1, 1, 2'd2, 32'h0000_1F15);
    step("R7 clear",   0, 0, 0, 5'b00001, 0, 1, 2'd1, 32'h0000_0000);
    step("R7 rise wins", 0, 0, 0, 5'b00011, 0, 1, 2'd1, 32'h0000_0000);
    step("R7 write one", 0, 0, 0, 5'b00011, 0, 1, 2'd1, 32'hFFFF_FFFF);
    step("R8 drop",    0, 0, 0, 5'b00000, 0, 0, 2'd0, 0);
    step("R11 code ro", 0, 0, 0, 5'b00000, 0, 1, 2'd1, 32'hFFFF_FFFF);
    step("R6 disabled", 0, 0, 0, 5'b00000, 0, 1, 2'd2, 32'h0000_0000);
    step("R6 disabled", 0, 0, 0, 5'b10100, 0, 0, 2'd0, 0);
    step("R9 enable",   0, 0, 0, 5'b10100, 0, 1, 2'd2, 32'h0000_1001);

    for (int i = 0; i < 600; i++) begin
      logic [4:0] hw;
      hw = hw_irq_i;
      for (int b = 0; b < 5; b++) if ($urandom % 4 == 0) hw[b] = ~hw[b];
      step("RND", ($urandom % 8) == 0, 4'($urandom), $urandom, hw,
           ($urandom % 8) == 0, ($urandom % 4) == 0, 2'($urandom), $urandom);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule